// File: doc/BRIEF.md
# External Bus Idle-State Sequencer

This block runs read and write cycles on an external memory bus that is split into several areas, each with its own active-low chip-select. An internal master hands it one access at a time: an address, an area number, a direction and write data. The block then steps the bus through its states. T1 puts the address out and selects the area. T2, and T3 for areas set to three-state timing, drive the read or write strobe. The last state pulses `done`, and read data is captured on the clock edge that ends that state.

On a loaded board, the read strobe can release later than the chip-select of the next area goes active. To prevent the two from overlapping, the block can place one idle state between a read and a directly following access to a different area. In that idle state no chip-select and no strobe is active. A one-bit setting turns this on or off, and it comes out of reset switched on. No idle state is added in these cases:
- the next access targets the same area;
- the previous access was a write;
- the bus already sat idle for at least one clock.

The request side is a valid/ready stream. The master holds `req_valid` and all request fields stable until a clock edge where `req_ready` is high. `req_ready` depends only on the bus state, never on `req_valid`. It is high in the idle state and in the last state of a cycle, so a request waiting there starts the next cycle without a gap. The read response side has no back-pressure, because the bus cannot stall: `rsp_valid` is a one-clock pulse that the consumer must take.

Top module: `ebi_idle_seq`

## Requirements
- R1: Reset state: every chip-select is high (inactive), both strobes are high, `busy` and `done` are low, and idle insertion is enabled.
- R2: Two-state access: in T1 only the addressed area's chip-select is low, the address is valid and both strobes are high. In T2 the chip-select stays low, the direction's strobe is low and `done` is high for that one clock.
- R3: For an area whose `cfg_area_three` bit is 1, the access has three states (T1, T2, T3). The strobe is low in T2 and T3, and `done` is high only in T3.
- R4: A request accepted in the last state of a cycle to the same area starts its T1 on the very next clock.
- R5: With insertion enabled, a read followed directly by an access to a different area gets exactly one idle state. During that state all chip-selects and both strobes are high and `busy` is high.
- R6: With insertion disabled, a read followed directly by an access to a different area starts T1 on the next clock.
- R7: A write followed directly by an access to a different area starts T1 on the next clock.
- R8: A request accepted while the bus is idle starts T1 on the following clock, with no idle state, whatever the previous access was.
- R9: `req_ready` is high, and `busy` low, exactly in the idle state and in the last state of a cycle. A request is taken only at an edge where both `req_valid` and `req_ready` are high.
- R10: On the edge that ends a read's last state, `bus_din` is captured. It appears on `rsp_data` with `rsp_valid` high for one clock right after. Writes produce no `rsp_valid`.
- R11: The insertion setting and the per-area state count are used as they stand at the accepting edge. A write to the setting on that same edge applies only from the next accepted request. Changing either input during a cycle alters neither that cycle nor an idle state already scheduled.
- R12: At most one chip-select is low at any time, and a strobe is low only while a chip-select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bus state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this clock |
| req_addr | input | ADDR_W | Access address |
| req_area | input | AREA_W | Target area number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| cfg_area_three | input | N_AREAS | Per area: 1 = three-state access, 0 = two-state |
| cfg_idle_we | input | 1 | Write strobe for the idle-insertion setting |
| cfg_idle_val | input | 1 | New setting: 1 = insert idle state, 0 = do not |
| bus_addr | output | ADDR_W | External address bus |
| bus_dout | output | DATA_W | External write data |
| bus_din | input | DATA_W | External read data |
| bus_cs_n | output | N_AREAS | Active-low chip-selects, one per area |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | High in the last state of each access |
| busy | output | 1 | Inverse of `req_ready` |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | DATA_W | Captured read data |

## Verification
The bench chains back-to-back accesses of these kinds:
- same-area reads, which separate the zero-gap path from a spurious idle state;
- read-to-other-area pairs after both two- and three-state reads, which show that exactly one idle state is inserted;
- write-to-other-area pairs, which show that a write never adds a gap;
- a request arriving on an already idle bus, which must show a gap of one clock, not two.

It then switches the insertion setting on the same edge as an accept, in both directions, to show that the old value governs that accept. It also changes an area's state count during a live cycle to show that only the next access picks the change up. For each access, the monitor measures the gap after the previous `done`, the number of states and the strobe pattern, and checks read data against a model of the external memory.

// File: rtl/ebi_pkg.sv
package ebi_pkg;
  typedef enum logic [2:0] {
    BS_IDLE = 3'd0,
    BS_T1   = 3'd1,
    BS_T2   = 3'd2,
    BS_T3   = 3'd3,
    BS_TI   = 3'd4
  } bus_state_e;
endpackage

// File: rtl/ebi_gap_ctrl.sv
// Holds the idle-insertion setting and remembers the previous access,
// then decides whether the next accepted access must be preceded by TI.
module ebi_gap_ctrl #(
  parameter int AREA_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_val,
  input  logic              accept,
  input  logic [AREA_W-1:0] req_area,
  input  logic              req_write,
  input  logic              bus_quiet,
  output logic              insert_idle
);
  logic              idle_en_q;
  logic              prev_live_q;
  logic              prev_read_q;
  logic [AREA_W-1:0] prev_area_q;

  // setting register, resets to "insert"
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idle_en_q <= 1'b1;
    else if (cfg_we) idle_en_q <= cfg_val;
  end

  // previous-access memory; a clock spent idle forgets it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_live_q <= 1'b0;
      prev_read_q <= 1'b0;
      prev_area_q <= '0;
    end else if (accept) begin
      prev_live_q <= 1'b1;
      prev_read_q <= ~req_write;
      prev_area_q <= req_area;
    end else if (bus_quiet) begin
      prev_live_q <= 1'b0;
    end
  end

  always_comb begin
    insert_idle = idle_en_q && prev_live_q && prev_read_q && !bus_quiet
                  && (req_area != prev_area_q);
  end

  // R1: setting comes out of reset enabled
  p_reset_enable_r1: assert property (@(posedge clk) (!rst_n) |=> idle_en_q);

  // R11: setting only moves on a write strobe
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> $stable(idle_en_q));
endmodule

// File: rtl/ebi_cycle_seq.sv
// Bus state sequencer: accepts requests, walks T1/T2/T3/TI.
module ebi_cycle_seq
  import ebi_pkg::*;
#(
  parameter int N_AREAS = 4,
  parameter int AREA_W  = 2,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [AREA_W-1:0]  req_area,
  input  logic               req_write,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [N_AREAS-1:0] area_three,
  input  logic               insert_idle,
  output bus_state_e         state,
  output logic [AREA_W-1:0]  cur_area,
  output logic [ADDR_W-1:0]  cur_addr,
  output logic [DATA_W-1:0]  cur_wdata,
  output logic               cur_write,
  output logic               last,
  output logic               ready,
  output logic               accept
);
  bus_state_e state_q, state_d;
  logic       three_q;

  always_comb begin
    last   = (state_q == BS_T3) || (state_q == BS_T2 && !three_q);
    ready  = (state_q == BS_IDLE) || last;
    accept = req_valid && ready;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BS_IDLE: if (accept) state_d = insert_idle ? BS_TI : BS_T1;
      BS_T1:   state_d = BS_T2;
      BS_T2:   if (three_q) state_d = BS_T3;
               else state_d = accept ? (insert_idle ? BS_TI : BS_T1) : BS_IDLE;
      BS_T3:   state_d = accept ? (insert_idle ? BS_TI : BS_T1) : BS_IDLE;
      BS_TI:   state_d = BS_T1;
      default: state_d = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= BS_IDLE;
    else        state_q <= state_d;
  end

  // access context captured at the accepting edge only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_area  <= '0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_write <= 1'b0;
      three_q   <= 1'b0;
    end else if (accept) begin
      cur_area  <= req_area;
      cur_addr  <= req_addr;
      cur_wdata <= req_wdata;
      cur_write <= req_write;
      three_q   <= area_three[req_area];
    end
  end

  assign state = state_q;

  // R2: T1 always moves to T2
  p_t1_to_t2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == BS_T1 |=> state_q == BS_T2);

  // R5: an idle state lasts one clock and is followed by T1
  p_ti_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == BS_TI |=> state_q == BS_T1);

  // R5: TI only appears right after an accept
  p_ti_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == BS_TI |-> $past(accept));

  // R8: an accept on a quiet bus goes straight to T1
  p_quiet_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BS_IDLE && accept) |=> state_q == BS_T1);

  // R11: the cycle context stays put while a cycle runs
  p_ctx_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != BS_IDLE && !ready) |=> ($stable(cur_area) && $stable(three_q)));
endmodule

// File: rtl/ebi_pin_drive.sv
// Decodes the bus state into pins and captures read data.
module ebi_pin_drive
  import ebi_pkg::*;
#(
  parameter int N_AREAS = 4,
  parameter int AREA_W  = 2,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  bus_state_e         state,
  input  logic [AREA_W-1:0]  cur_area,
  input  logic [ADDR_W-1:0]  cur_addr,
  input  logic [DATA_W-1:0]  cur_wdata,
  input  logic               cur_write,
  input  logic               last,
  input  logic [DATA_W-1:0]  bus_din,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_dout,
  output logic [N_AREAS-1:0] bus_cs_n,
  output logic               bus_rd_n,
  output logic               bus_wr_n,
  output logic               done,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data
);
  logic sel_phase;
  logic strobe_phase;

  always_comb begin
    sel_phase    = (state == BS_T1) || (state == BS_T2) || (state == BS_T3);
    strobe_phase = (state == BS_T2) || (state == BS_T3);
    bus_rd_n     = !(strobe_phase && !cur_write);
    bus_wr_n     = !(strobe_phase && cur_write);
    bus_addr     = cur_addr;
    bus_dout     = cur_wdata;
    done         = last;
  end

  for (genvar g = 0; g < N_AREAS; g++) begin : g_cs
    assign bus_cs_n[g] = !(sel_phase && (cur_area == AREA_W'(g)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= last && !cur_write;
      if (last && !cur_write) rsp_data <= bus_din;
    end
  end

  // R12: never more than one area selected
  p_cs_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));

  // R12: a strobe only under a chip-select
  p_strobe_under_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> (bus_cs_n != {N_AREAS{1'b1}}));

  // R2: done lasts one clock
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: response follows a read's last state
  p_rsp_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(done && !bus_rd_n));
endmodule

// File: rtl/ebi_idle_seq.sv
module ebi_idle_seq
  import ebi_pkg::*;
#(
  parameter int N_AREAS = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  localparam int AREA_W = (N_AREAS > 1) ? $clog2(N_AREAS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [AREA_W-1:0]  req_area,
  input  logic               req_write,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [N_AREAS-1:0] cfg_area_three,
  input  logic               cfg_idle_we,
  input  logic               cfg_idle_val,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_dout,
  input  logic [DATA_W-1:0]  bus_din,
  output logic [N_AREAS-1:0] bus_cs_n,
  output logic               bus_rd_n,
  output logic               bus_wr_n,
  output logic               done,
  output logic               busy,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data
);
  bus_state_e        state;
  logic [AREA_W-1:0] cur_area;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic              cur_write;
  logic              last;
  logic              ready;
  logic              accept;
  logic              insert_idle;

  ebi_gap_ctrl #(.AREA_W(AREA_W)) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_idle_we),
    .cfg_val    (cfg_idle_val),
    .accept     (accept),
    .req_area   (req_area),
    .req_write  (req_write),
    .bus_quiet  (state == BS_IDLE),
    .insert_idle(insert_idle)
  );

  ebi_cycle_seq #(
    .N_AREAS(N_AREAS), .AREA_W(AREA_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_area   (req_area),
    .req_write  (req_write),
    .req_wdata  (req_wdata),
    .area_three (cfg_area_three),
    .insert_idle(insert_idle),
    .state      (state),
    .cur_area   (cur_area),
    .cur_addr   (cur_addr),
    .cur_wdata  (cur_wdata),
    .cur_write  (cur_write),
    .last       (last),
    .ready      (ready),
    .accept     (accept)
  );

  ebi_pin_drive #(
    .N_AREAS(N_AREAS), .AREA_W(AREA_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .cur_area (cur_area),
    .cur_addr (cur_addr),
    .cur_wdata(cur_wdata),
    .cur_write(cur_write),
    .last     (last),
    .bus_din  (bus_din),
    .bus_addr (bus_addr),
    .bus_dout (bus_dout),
    .bus_cs_n (bus_cs_n),
    .bus_rd_n (bus_rd_n),
    .bus_wr_n (bus_wr_n),
    .done     (done),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );

  assign req_ready = ready;
  assign busy      = !ready;

  // R9: busy is exactly the complement of ready, and done implies ready
  p_done_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !busy));
endmodule

// File: tb/tb_ebi_idle_seq.sv
`timescale 1ns/1ps
module tb_ebi_idle_seq;
  localparam int NA = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_area = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [NA-1:0] cfg_area_three = 4'b1010;
  logic        cfg_idle_we = 1'b0;
  logic        cfg_idle_val = 1'b0;
  logic [15:0] bus_addr, bus_dout, bus_din, rsp_data;
  logic [NA-1:0] bus_cs_n;
  logic        bus_rd_n, bus_wr_n, done, busy, rsp_valid;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  // external memory model: read data derived from the address
  function automatic logic [15:0] mem_word(input logic [15:0] a);
    return ~a ^ 16'h3C3C;
  endfunction
  assign bus_din = mem_word(bus_addr);

  ebi_idle_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_area(req_area), .req_write(req_write),
    .req_wdata(req_wdata), .cfg_area_three(cfg_area_three),
    .cfg_idle_we(cfg_idle_we), .cfg_idle_val(cfg_idle_val),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .done(done), .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  typedef struct {
    int          area;
    logic [15:0] addr;
    bit          wr;
    int          states;
    int          gap;     // -1: not checked
    string       tag;
  } item_t;
  item_t exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // driver: offers one request, pushes the expected access at acceptance
  task automatic send(input int area, input logic [15:0] addr, input bit wr,
                      input int gap, input string tag,
                      input bit do_cfg, input bit cfg_v);
    item_t it;
    req_area  = 2'(area);
    req_addr  = addr;
    req_write = wr;
    req_wdata = addr ^ 16'h5A5A;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    if (do_cfg) begin
      cfg_idle_we  = 1'b1;
      cfg_idle_val = cfg_v;
    end
    it.area   = area;
    it.addr   = addr;
    it.wr     = wr;
    it.states = cfg_area_three[area] ? 3 : 2;
    it.gap    = gap;
    it.tag    = tag;
    exp_q.push_back(it);
    @(negedge clk);
    cfg_idle_we = 1'b0;
    req_valid   = 1'b0;
  endtask

  task automatic wait_idle();
    req_valid = 1'b0;
    do @(negedge clk); while (!(req_ready && !done));
  endtask

  // monitor / scoreboard
  initial begin
    int    cyc = 0;
    int    last_done = -100;
    bit    in_acc = 0;
    int    cnt = 0;
    bit    pend = 0;
    logic [15:0] pend_data = '0;
    item_t cur;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        // R10: response exactly one clock after a read's last state
        if (pend)
          check(rsp_valid && rsp_data == pend_data, "R10", "read data",
                int'(rsp_data), int'(pend_data));
        else if (rsp_valid)
          check(0, "R10", "unexpected rsp_valid", 1, 0);
        pend = 0;
        if ($countones(~bus_cs_n) > 1)
          check(0, "R12", "selects low", $countones(~bus_cs_n), 1);
        if (bus_cs_n == '1) begin
          check(bus_rd_n && bus_wr_n, "R12", "strobe without select",
                int'({bus_rd_n, bus_wr_n}), 3);
          if (in_acc) check(0, "R2", "select dropped mid-cycle", 0, 1);
        end else begin
          int idx = 0;
          for (int i = 0; i < NA; i++) if (!bus_cs_n[i]) idx = i;
          check(busy == !done, "R9", "busy vs last state", int'(busy), int'(!done));
          if (!in_acc) begin
            if (exp_q.size() == 0) begin
              check(0, "R9", "unrequested access", 1, 0);
            end else begin
              cur = exp_q.pop_front();
              check(idx == cur.area, "R2", "area at T1", idx, cur.area);
              check(bus_addr == cur.addr, "R2", "address at T1",
                    int'(bus_addr), int'(cur.addr));
              check(bus_rd_n && bus_wr_n, "R2", "strobes at T1",
                    int'({bus_rd_n, bus_wr_n}), 3);
              if (cur.gap >= 0)
                check(cyc - last_done - 1 == cur.gap, cur.tag, "gap clocks",
                      cyc - last_done - 1, cur.gap);
              in_acc = 1;
              cnt = 1;
            end
          end else begin
            cnt++;
            check(idx == cur.area, "R3", "area held", idx, cur.area);
            check(bus_rd_n == cur.wr && bus_wr_n == !cur.wr, "R3", "strobe phase",
                  int'({bus_rd_n, bus_wr_n}), int'({cur.wr, !cur.wr}));
            if (cur.wr)
              check(bus_dout == (cur.addr ^ 16'h5A5A), "R2", "write data",
                    int'(bus_dout), int'(cur.addr ^ 16'h5A5A));
          end
        end
        if (done) begin
          if (!in_acc) check(0, "R2", "done outside access", 1, 0);
          else begin
            check(cnt == cur.states, "R3", "state count", cnt, cur.states);
            in_acc = 0;
            last_done = cyc;
            if (!cur.wr) begin
              pend = 1;
              pend_data = mem_word(cur.addr);
            end
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    check(0, "R9", "watchdog expired", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(bus_cs_n == '1, "R1", "chip-selects in reset", int'(bus_cs_n), 15);
    check(bus_rd_n && bus_wr_n, "R1", "strobes in reset",
          int'({bus_rd_n, bus_wr_n}), 3);
    check(!busy && !done, "R1", "busy/done in reset", int'({busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R9", "ready when idle", int'(req_ready), 1);

    send(0, 16'h1000, 0, -1, "R2", 0, 0);
    send(0, 16'h1002, 0,  0, "R4", 0, 0);  // same area, no gap
    send(1, 16'h2000, 0,  1, "R1", 0, 0);  // default enabled -> TI
    send(2, 16'h3000, 0,  1, "R5", 0, 0);  // after three-state read
    send(3, 16'h4000, 1,  1, "R5", 0, 0);  // read then write elsewhere
    send(0, 16'h1004, 0,  0, "R7", 0, 0);  // after a write: no gap
    wait_idle();
    send(1, 16'h2002, 0,  1, "R8", 0, 0);  // from idle: one clock, no TI
    send(2, 16'h3002, 0,  1, "R11", 1, 0); // disable on accept edge: old value
    send(3, 16'h4002, 0,  0, "R6", 0, 0);  // now disabled
    send(0, 16'h1006, 0,  0, "R11", 1, 1); // enable on accept edge: old value
    send(1, 16'h2004, 0,  1, "R11", 0, 0); // enabled again
    wait_idle();
    cfg_area_three[0] = 1'b0;
    send(0, 16'h1008, 1,  1, "R8", 0, 0);
    cfg_area_three[0] = 1'b1;              // mid-cycle change
    send(0, 16'h100A, 0,  0, "R11", 0, 0);
    wait_idle();
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9", "accesses left unseen", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule